// File: doc/BRIEF.md
# Segment Capability Translation Buffer

This block turns a segment-relative virtual address into a physical word address. It holds a set of evaluated capability entries and a small table of per-segment pointers. The lookup has two levels. The upper bits of the address pick a slot in the pointer table. That slot names the entry that holds the capability for the selected capability segment. The block then searches the entries for one that belongs to that segment, which means its segment tag equals the slot contents, and whose capability tag equals the index field of the address. The search examines four entries per cycle.

On a match the block checks the offset against the segment size and the requested rights against the granted rights. It then returns either base plus offset or a fault. When no entry matches, or when the slot is empty, it reports a miss, and the controller refills the buffer through a separate load port. A flush input empties the buffer in a single cycle.

Virtual address layout (28 bits): bits [27:24] select the segment slot, bits [23:16] are the capability index, and bits [15:0] are the word offset. Rights are encoded as bit 2 = read, bit 1 = write and bit 0 = execute. This encoding applies both to the request and to the low bits of an entry's 7-bit rights field.

Top module: `cap_xlate_buf`

## Requirements
- R1: After reset, `rsp_valid` is low and `req_ready` is high.
- R2: A request whose selected segment slot is empty gets a miss response exactly one cycle after it is accepted, with no scan.
- R3: A load with `ld_segcap` set writes the loaded entry number into segment slot `ld_seg`. A later load of another entry for the same slot replaces the pointer.
- R4: An entry matches only if it is valid, its segment tag equals the entry number held in the selected slot, and its capability tag equals address bits [23:16]. The same index loaded under another segment does not match.
- R5: The search covers four entries per cycle, so a hit on entry e responds e/4 + 2 cycles after acceptance (integer division).
- R6: When no entry matches, a miss is reported 17 cycles after acceptance. `req_ready` stays low from acceptance until the response.
- R7: A matching entry with offset greater than or equal to its size gives a fault, not a hit.
- R8: A matching entry gives a fault when any requested right bit is clear in the entry's rights field. Set rights bits beyond those requested do no harm.
- R9: A successful hit returns `rsp_paddr` = base + offset modulo 2^20 and the matching entry number on `rsp_entry`. Each response raises exactly one of hit, miss or fault.
- R10: Each entry keeps a 7-bit reference count. A load clears it, each successful hit adds one and it saturates at 127. A fault leaves it unchanged. `rsp_refs` shows the count after the current hit.
- R11: `flush` clears every entry and every slot in one cycle. It aborts an ongoing search without a response, and `req_ready` is low while `flush` is high.
- R12: When several entries match, the lowest numbered one is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries and slots |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_vaddr | input | 28 | Virtual address: slot, capability index, offset |
| req_rwx | input | 3 | Requested rights (read, write, execute) |
| ld_en | input | 1 | Write one entry |
| ld_idx | input | 6 | Entry number to write |
| ld_ctag | input | 8 | Capability tag of the loaded entry |
| ld_stag | input | 6 | Segment tag (holder entry number) |
| ld_base | input | 20 | Physical base address |
| ld_size | input | 16 | Segment size in words |
| ld_acc | input | 7 | Granted rights field |
| ld_segcap | input | 1 | Also point slot `ld_seg` at this entry |
| ld_seg | input | 4 | Slot written when `ld_segcap` is set |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No matching entry or empty slot |
| rsp_fault | output | 1 | Bounds or rights violation |
| rsp_paddr | output | 20 | Physical word address on hit |
| rsp_entry | output | 6 | Matching entry number on hit or fault |
| rsp_refs | output | 7 | Reference count of the hit entry |

## Verification
The hardest conditions to reach are a search aborted part-way by a flush and saturation of the reference count. Each test first builds a two-level chain through the load port: a holder entry that sets a slot pointer, then a data entry whose segment tag names the holder. The data entry is placed in a chosen group, which fixes the response latency. The abort test places that entry late in the table, raises flush two cycles into the search, and watches that no response appears. A following lookup must then miss at once. The saturation test repeats the same hit well past 127 references and then checks that a reload restarts the count.

// File: rtl/cap_xlate_pkg.sv
// Shared constants and types for the capability translation buffer.
// Assumes ENTRY_N and GROUP_N are powers of two and ENTRY_N >= GROUP_N.
package cap_xlate_pkg;
    localparam int ENTRY_N  = 64;
    localparam int SEG_N    = 16;
    localparam int GROUP_N  = 4;
    localparam int CTAG_W   = 8;
    localparam int BASE_W   = 20;
    localparam int SIZE_W   = 16;
    localparam int ACC_W    = 7;
    localparam int CNT_W    = 7;
    localparam int RWX_W    = 3;
    localparam int OFF_W    = 16;

    localparam int EIDX_W   = $clog2(ENTRY_N);
    localparam int SEG_W    = $clog2(SEG_N);
    localparam int LANE_W   = $clog2(GROUP_N);
    localparam int STEP_N   = ENTRY_N / GROUP_N;
    localparam int STEP_W   = $clog2(STEP_N);
    localparam int VA_W     = SEG_W + CTAG_W + OFF_W;
    localparam int CIDX_LSB = OFF_W;
    localparam int SEG_LSB  = OFF_W + CTAG_W;

    typedef struct packed {
        logic              valid;
        logic [CTAG_W-1:0] ctag;
        logic [EIDX_W-1:0] stag;
        logic [BASE_W-1:0] base;
        logic [SIZE_W-1:0] size;
        logic [ACC_W-1:0]  acc;
        logic [CNT_W-1:0]  cnt;
    } cap_entry_t;

    typedef struct packed {
        logic              valid;
        logic [EIDX_W-1:0] holder;
    } seg_slot_t;

    typedef enum logic {ST_IDLE, ST_SCAN} scan_state_t;
endpackage

// File: rtl/cap_seg_slots.sv
// Per-segment pointer table: each slot names the entry holding that
// capability segment. Flush has priority over a write in the same cycle.
module cap_seg_slots
    import cap_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_sel,
    input  logic [EIDX_W-1:0] wr_holder,
    input  logic [SEG_W-1:0]  rd_sel,
    output seg_slot_t         rd_slot
);
    seg_slot_t slots [SEG_N];

    // Slot storage: reset, flush-invalidate, or point one slot at an entry.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int i = 0; i < SEG_N; i++) begin
                slots[i] <= '0;
            end
        end else if (wr_en) begin
            slots[wr_sel] <= '{valid: 1'b1, holder: wr_holder};
        end
    end

    // Asynchronous read of the slot chosen by the incoming address.
    assign rd_slot = slots[rd_sel];
endmodule

// File: rtl/cap_entry_file.sv
// Capability entry storage with a load port, a saturating reference-count
// bump port and a group read port presenting GROUP_N adjacent entries.
// A load to the entry being bumped in the same cycle wins.
module cap_entry_file
    import cap_xlate_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic                           ld_en,
    input  logic [EIDX_W-1:0]              ld_idx,
    input  cap_entry_t                     ld_ent,
    input  logic                           bump_en,
    input  logic [EIDX_W-1:0]              bump_idx,
    input  logic [STEP_W-1:0]              grp_sel,
    output cap_entry_t [GROUP_N-1:0]       grp_ent
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    cap_entry_t ents [ENTRY_N];

    // Entry storage: reset/flush clear, hit count bump, then load (load wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRY_N; i++) begin
                ents[i] <= '0;
            end
        end else if (flush) begin
            for (int i = 0; i < ENTRY_N; i++) begin
                ents[i].valid <= 1'b0;
            end
        end else begin
            if (bump_en && ents[bump_idx].cnt != CNT_MAX) begin
                ents[bump_idx].cnt <= ents[bump_idx].cnt + CNT_W'(1);
            end
            if (ld_en) begin
                ents[ld_idx]       <= ld_ent;
                ents[ld_idx].valid <= 1'b1;
                ents[ld_idx].cnt   <= '0;
            end
        end
    end

    // One read lane per entry of the group currently being searched.
    for (genvar g = 0; g < GROUP_N; g++) begin : g_lane
        assign grp_ent[g] = ents[{grp_sel, LANE_W'(g)}];
    end
endmodule

// File: rtl/cap_group_match.sv
// Compares one group of entries against the search key and reports the
// lowest-numbered matching lane.
module cap_group_match
    import cap_xlate_pkg::*;
(
    input  cap_entry_t [GROUP_N-1:0] grp_ent,
    input  logic [EIDX_W-1:0]        key_stag,
    input  logic [CTAG_W-1:0]        key_ctag,
    output logic                     any_hit,
    output logic [LANE_W-1:0]        hit_lane
);
    logic [GROUP_N-1:0] lane_hit;

    for (genvar g = 0; g < GROUP_N; g++) begin : g_cmp
        assign lane_hit[g] = grp_ent[g].valid
                          && grp_ent[g].stag == key_stag
                          && grp_ent[g].ctag == key_ctag;
    end

    // Priority encode: scanning from the top leaves the lowest lane.
    always_comb begin
        hit_lane = '0;
        for (int g = GROUP_N - 1; g >= 0; g--) begin
            if (lane_hit[g]) hit_lane = LANE_W'(g);
        end
    end

    assign any_hit = |lane_hit;
endmodule

// File: rtl/cap_access_check.sv
// Bounds and rights test for a matched entry, plus address formation.
// Requested rights are zero-extended into the rights field's width.
module cap_access_check
    import cap_xlate_pkg::*;
(
    input  logic [BASE_W-1:0] base,
    input  logic [SIZE_W-1:0] size,
    input  logic [ACC_W-1:0]  acc,
    input  logic [OFF_W-1:0]  offset,
    input  logic [RWX_W-1:0]  rwx,
    output logic              allowed,
    output logic [BASE_W-1:0] paddr
);
    logic [ACC_W-1:0] want;
    logic             in_bounds;
    logic             rights_ok;

    assign want      = ACC_W'(rwx);
    assign in_bounds = SIZE_W'(offset) < size;
    assign rights_ok = (want & ~acc) == '0;
    assign allowed   = in_bounds && rights_ok;
    assign paddr     = base + BASE_W'(offset);
endmodule

// File: rtl/cap_xlate_buf.sv
// Top of the capability translation buffer. Accepts one lookup at a time,
// reads the segment slot, scans entry groups one per cycle and registers a
// one-cycle response. Assumes the controller does not load during a search.
module cap_xlate_buf
    import cap_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [RWX_W-1:0]  req_rwx,
    input  logic              ld_en,
    input  logic [EIDX_W-1:0] ld_idx,
    input  logic [CTAG_W-1:0] ld_ctag,
    input  logic [EIDX_W-1:0] ld_stag,
    input  logic [BASE_W-1:0] ld_base,
    input  logic [SIZE_W-1:0] ld_size,
    input  logic [ACC_W-1:0]  ld_acc,
    input  logic              ld_segcap,
    input  logic [SEG_W-1:0]  ld_seg,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic [BASE_W-1:0] rsp_paddr,
    output logic [EIDX_W-1:0] rsp_entry,
    output logic [CNT_W-1:0]  rsp_refs
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEP_N - 1);
    localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

    scan_state_t               state;
    logic [STEP_W-1:0]         grp;
    logic [EIDX_W-1:0]         key_stag;
    logic [CTAG_W-1:0]         key_ctag;
    logic [OFF_W-1:0]          key_off;
    logic [RWX_W-1:0]          key_rwx;

    seg_slot_t                 slot_rd;
    logic                      slot_ok;
    logic                      accept;
    logic                      scanning;
    cap_entry_t [GROUP_N-1:0]  grp_ent;
    cap_entry_t                hit_ent;
    logic                      m_hit;
    logic [LANE_W-1:0]         m_lane;
    logic [EIDX_W-1:0]         hit_idx;
    logic                      chk_ok;
    logic [BASE_W-1:0]         chk_paddr;
    logic                      bump_en;
    cap_entry_t                ld_ent;

    assign req_ready = (state == ST_IDLE) && !flush;
    assign accept    = req_valid && req_ready;
    assign scanning  = (state == ST_SCAN);
    assign slot_ok   = slot_rd.valid;

    assign ld_ent = '{valid: 1'b1, ctag: ld_ctag, stag: ld_stag, base: ld_base,
                      size: ld_size, acc: ld_acc, cnt: '0};

    cap_seg_slots i_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .wr_en     (ld_en && ld_segcap),
        .wr_sel    (ld_seg),
        .wr_holder (ld_idx),
        .rd_sel    (req_vaddr[SEG_LSB +: SEG_W]),
        .rd_slot   (slot_rd)
    );

    cap_entry_file i_entries (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .ld_en    (ld_en),
        .ld_idx   (ld_idx),
        .ld_ent   (ld_ent),
        .bump_en  (bump_en),
        .bump_idx (hit_idx),
        .grp_sel  (grp),
        .grp_ent  (grp_ent)
    );

    cap_group_match i_match (
        .grp_ent  (grp_ent),
        .key_stag (key_stag),
        .key_ctag (key_ctag),
        .any_hit  (m_hit),
        .hit_lane (m_lane)
    );

    assign hit_ent = grp_ent[m_lane];
    assign hit_idx = {grp, m_lane};

    cap_access_check i_check (
        .base    (hit_ent.base),
        .size    (hit_ent.size),
        .acc     (hit_ent.acc),
        .offset  (key_off),
        .rwx     (key_rwx),
        .allowed (chk_ok),
        .paddr   (chk_paddr)
    );

    assign bump_en = scanning && m_hit && chk_ok && !flush;

    // Search sequencer and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            grp       <= '0;
            key_stag  <= '0;
            key_ctag  <= '0;
            key_off   <= '0;
            key_rwx   <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
            rsp_entry <= '0;
            rsp_refs  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            if (flush) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (accept) begin
                            if (!slot_ok) begin
                                rsp_valid <= 1'b1;
                                rsp_miss  <= 1'b1;
                                rsp_paddr <= '0;
                                rsp_entry <= '0;
                                rsp_refs  <= '0;
                            end else begin
                                state    <= ST_SCAN;
                                grp      <= '0;
                                key_stag <= slot_rd.holder;
                                key_ctag <= req_vaddr[CIDX_LSB +: CTAG_W];
                                key_off  <= req_vaddr[OFF_W-1:0];
                                key_rwx  <= req_rwx;
                            end
                        end
                    end
                    ST_SCAN: begin
                        if (m_hit) begin
                            state     <= ST_IDLE;
                            rsp_valid <= 1'b1;
                            rsp_entry <= hit_idx;
                            if (chk_ok) begin
                                rsp_hit   <= 1'b1;
                                rsp_paddr <= chk_paddr;
                                rsp_refs  <= (hit_ent.cnt == CNT_MAX) ? CNT_MAX
                                                                      : hit_ent.cnt + CNT_W'(1);
                            end else begin
                                rsp_fault <= 1'b1;
                                rsp_paddr <= '0;
                                rsp_refs  <= '0;
                            end
                        end else if (grp == LAST_STEP) begin
                            state     <= ST_IDLE;
                            rsp_valid <= 1'b1;
                            rsp_miss  <= 1'b1;
                            rsp_paddr <= '0;
                            rsp_entry <= '0;
                            rsp_refs  <= '0;
                        end else begin
                            grp <= grp + STEP_W'(1);
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/cap_xlate_chk.sv
// Protocol checker for cap_xlate_buf, attached by bind. Watches the
// request/response handshake and the search length.
module cap_xlate_chk
    import cap_xlate_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic flush,
    input logic req_valid,
    input logic req_ready,
    input logic slot_ok,
    input logic scanning,
    input logic rsp_valid,
    input logic rsp_hit,
    input logic rsp_miss,
    input logic rsp_fault
);
    localparam int BUSY_W = $clog2(STEP_N + 2);

    logic [BUSY_W-1:0] busy_cnt;

    // Length of the current search in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !scanning) busy_cnt <= '0;
        else                     busy_cnt <= busy_cnt + BUSY_W'(1);
    end

    AST_EMPTY_SLOT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !slot_ok) |=> (rsp_valid && rsp_miss)); // R2

    AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1)); // R9

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault)); // R9

    AST_SCAN_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        scanning |-> !req_ready); // R6

    AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= BUSY_W'(STEP_N)); // R5

    AST_FLUSH_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !rsp_valid); // R11
endmodule

bind cap_xlate_buf cap_xlate_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .slot_ok   (slot_ok),
    .scanning  (scanning),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_fault (rsp_fault)
);

// File: tb/test_cap_xlate_buf.sv
`timescale 1ns/1ps
module test_cap_xlate_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [27:0] req_vaddr = '0;
    logic [2:0]  req_rwx = '0;
    logic        ld_en = 1'b0;
    logic [5:0]  ld_idx = '0;
    logic [7:0]  ld_ctag = '0;
    logic [5:0]  ld_stag = '0;
    logic [19:0] ld_base = '0;
    logic [15:0] ld_size = '0;
    logic [6:0]  ld_acc = '0;
    logic        ld_segcap = 1'b0;
    logic [3:0]  ld_seg = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [19:0] rsp_paddr;
    logic [5:0]  rsp_entry;
    logic [6:0]  rsp_refs;

    int n_checks = 0;
    int n_fails  = 0;

    // Results of the latest lookup.
    int          r_lat;
    logic        r_hit, r_miss, r_fault, r_busy;
    logic [19:0] r_paddr;
    logic [5:0]  r_entry;
    logic [6:0]  r_refs;

    always #2 clk = ~clk;

    cap_xlate_buf i_cap_xlate_buf (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_rwx(req_rwx),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_ctag(ld_ctag), .ld_stag(ld_stag),
        .ld_base(ld_base), .ld_size(ld_size), .ld_acc(ld_acc),
        .ld_segcap(ld_segcap), .ld_seg(ld_seg),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_entry(rsp_entry),
        .rsp_refs(rsp_refs)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    task automatic load(input logic [5:0] idx, input logic [7:0] ctag,
                        input logic [5:0] stag, input logic [19:0] base,
                        input logic [15:0] size, input logic [6:0] acc,
                        input logic segcap, input logic [3:0] seg);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = idx; ld_ctag = ctag; ld_stag = stag;
        ld_base = base; ld_size = size; ld_acc = acc;
        ld_segcap = segcap; ld_seg = seg;
        @(negedge clk);
        ld_en = 1'b0; ld_segcap = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    // Issue one lookup and record the outcome and its latency in cycles.
    task automatic lookup(input logic [3:0] seg, input logic [7:0] cidx,
                          input logic [15:0] off, input logic [2:0] rwx);
        logic got;
        @(negedge clk);
        req_vaddr = {seg, cidx, off};
        req_rwx   = rwx;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        got = 1'b0; r_lat = 0; r_busy = 1'b0;
        r_hit = 1'b0; r_miss = 1'b0; r_fault = 1'b0;
        r_paddr = '0; r_entry = '0; r_refs = '0;
        for (int i = 1; i <= 40 && !got; i++) begin
            if (i > 1) @(negedge clk);
            if (rsp_valid) begin
                got = 1'b1; r_lat = i;
                r_hit = rsp_hit; r_miss = rsp_miss; r_fault = rsp_fault;
                r_paddr = rsp_paddr; r_entry = rsp_entry; r_refs = rsp_refs;
            end else if (i == 1) begin
                r_busy = !req_ready;
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "rsp_valid after reset", 32'(rsp_valid), 0);
        check("R1", "req_ready after reset", 32'(req_ready), 1);
    endtask

    task automatic t_empty_slot();
        do_flush();
        lookup(4'h3, 8'h10, 16'd0, 3'b100);
        check("R2", "empty slot latency", r_lat, 1);
        check("R2", "empty slot miss", 32'(r_miss), 1);
    endtask

    task automatic t_two_level();
        do_flush();
        load(6'd40, 8'h00, 6'd0, 20'h0, 16'd1, 7'h0, 1'b1, 4'h2);
        load(6'd13, 8'h5A, 6'd40, 20'h12300, 16'd100, 7'b0000111, 1'b0, 4'h0);
        load(6'd50, 8'h00, 6'd0, 20'h0, 16'd1, 7'h0, 1'b1, 4'h5);
        lookup(4'h2, 8'h5A, 16'd7, 3'b100);
        check("R4", "hit via slot", 32'(r_hit), 1);
        check("R5", "latency entry 13", r_lat, 5);
        check("R9", "paddr", 32'(r_paddr), 32'h12307);
        check("R9", "entry", 32'(r_entry), 13);
        lookup(4'h5, 8'h5A, 16'd7, 3'b100);
        check("R4", "other segment same index misses", 32'(r_miss), 1);
        check("R6", "full scan latency", r_lat, 17);
        check("R6", "ready low during scan", 32'(r_busy), 1);
        lookup(4'h2, 8'h5B, 16'd7, 3'b100);
        check("R4", "wrong index misses", 32'(r_miss), 1);
        load(6'd51, 8'h00, 6'd0, 20'h0, 16'd1, 7'h0, 1'b1, 4'h2);
        lookup(4'h2, 8'h5A, 16'd7, 3'b100);
        check("R3", "repointed slot misses old entry", 32'(r_miss), 1);
        load(6'd14, 8'h5A, 6'd51, 20'h00400, 16'd10, 7'b0000111, 1'b0, 4'h0);
        lookup(4'h2, 8'h5A, 16'd3, 3'b001);
        check("R3", "repointed slot hits new entry", 32'(r_entry), 14);
        check("R3", "repointed slot paddr", 32'(r_paddr), 32'h00403);
    endtask

    task automatic t_latency();
        do_flush();
        load(6'd30, 8'h00, 6'd0, 20'h0, 16'd1, 7'h0, 1'b1, 4'h1);
        load(6'd0, 8'h01, 6'd30, 20'h00100, 16'd50, 7'h07, 1'b0, 4'h0);
        load(6'd63, 8'h02, 6'd30, 20'h00200, 16'd50, 7'h07, 1'b0, 4'h0);
        lookup(4'h1, 8'h01, 16'd0, 3'b100);
        check("R5", "entry 0 latency", r_lat, 2);
        check("R5", "entry 0 hit", 32'(r_hit), 1);
        lookup(4'h1, 8'h02, 16'd1, 3'b100);
        check("R5", "entry 63 latency", r_lat, 17);
        check("R5", "entry 63 hit", 32'(r_hit), 1);
    endtask

    task automatic t_bounds();
        do_flush();
        load(6'd20, 8'h00, 6'd0, 20'h0, 16'd1, 7'h0, 1'b1, 4'h7);
        load(6'd21, 8'h33, 6'd20, 20'h08000, 16'd100, 7'h07, 1'b0, 4'h0);
        load(6'd22, 8'h34, 6'd20, 20'h08000, 16'd0, 7'h07, 1'b0, 4'h0);
        lookup(4'h7, 8'h33, 16'd99, 3'b100);
        check("R7", "last word hits", 32'(r_hit), 1);
        lookup(4'h7, 8'h33, 16'd100, 3'b100);
        check("R7", "offset == size faults", 32'(r_fault), 1);
        check("R7", "fault entry", 32'(r_entry), 21);
        lookup(4'h7, 8'h33, 16'hFFFF, 3'b100);
        check("R7", "max offset faults", 32'(r_fault), 1);
        lookup(4'h7, 8'h34, 16'd0, 3'b000);
        check("R7", "zero size faults", 32'(r_fault), 1);
    endtask

    task automatic t_rights();
        do_flush();
        load(6'd8, 8'h00, 6'd0, 20'h0, 16'd1, 7'h0, 1'b1, 4'h9);
        load(6'd33, 8'h77, 6'd8, 20'h10000, 16'd64, 7'b1111010, 1'b0, 4'h0);
        lookup(4'h9, 8'h77, 16'd5, 3'b010);
        check("R8", "granted write hits", 32'(r_hit), 1);
        lookup(4'h9, 8'h77, 16'd5, 3'b100);
        check("R8", "read not granted faults", 32'(r_fault), 1);
        lookup(4'h9, 8'h77, 16'd5, 3'b001);
        check("R8", "execute not granted faults", 32'(r_fault), 1);
        lookup(4'h9, 8'h77, 16'd5, 3'b000);
        check("R8", "no rights requested hits", 32'(r_hit), 1);
    endtask

    task automatic t_wrap();
        do_flush();
        load(6'd2, 8'h00, 6'd0, 20'h0, 16'd1, 7'h0, 1'b1, 4'hA);
        load(6'd3, 8'h11, 6'd2, 20'hFFFF0, 16'h0100, 7'h07, 1'b0, 4'h0);
        lookup(4'hA, 8'h11, 16'h0020, 3'b100);
        check("R9", "wrapped paddr", 32'(r_paddr), 32'h00010);
    endtask

    task automatic t_refs();
        do_flush();
        load(6'd4, 8'h00, 6'd0, 20'h0, 16'd1, 7'h0, 1'b1, 4'hB);
        load(6'd5, 8'h44, 6'd4, 20'h00500, 16'd10, 7'h04, 1'b0, 4'h0);
        lookup(4'hB, 8'h44, 16'd1, 3'b100);
        check("R10", "refs after first hit", 32'(r_refs), 1);
        lookup(4'hB, 8'h44, 16'd1, 3'b100);
        check("R10", "refs after second hit", 32'(r_refs), 2);
        lookup(4'hB, 8'h44, 16'd1, 3'b010);
        check("R10", "fault response", 32'(r_fault), 1);
        lookup(4'hB, 8'h44, 16'd1, 3'b100);
        check("R10", "fault leaves count", 32'(r_refs), 3);
        for (int k = 0; k < 130; k++) lookup(4'hB, 8'h44, 16'd1, 3'b100);
        check("R10", "saturated refs", 32'(r_refs), 127);
        load(6'd5, 8'h44, 6'd4, 20'h00500, 16'd10, 7'h04, 1'b0, 4'h0);
        lookup(4'hB, 8'h44, 16'd1, 3'b100);
        check("R10", "reload resets refs", 32'(r_refs), 1);
    endtask

    task automatic t_priority();
        do_flush();
        load(6'd60, 8'h00, 6'd0, 20'h0, 16'd1, 7'h0, 1'b1, 4'hC);
        load(6'd10, 8'h66, 6'd60, 20'h00A00, 16'd10, 7'h07, 1'b0, 4'h0);
        load(6'd9,  8'h66, 6'd60, 20'h00900, 16'd10, 7'h07, 1'b0, 4'h0);
        lookup(4'hC, 8'h66, 16'd0, 3'b100);
        check("R12", "lowest lane in group", 32'(r_entry), 9);
        check("R12", "same-group latency", r_lat, 4);
        load(6'd20, 8'h67, 6'd60, 20'h02000, 16'd10, 7'h07, 1'b0, 4'h0);
        load(6'd5,  8'h67, 6'd60, 20'h00050, 16'd10, 7'h07, 1'b0, 4'h0);
        lookup(4'hC, 8'h67, 16'd0, 3'b100);
        check("R12", "earlier group wins", 32'(r_entry), 5);
        check("R12", "earlier group paddr", 32'(r_paddr), 32'h00050);
    endtask

    task automatic t_flush();
        logic seen;
        do_flush();
        load(6'd1, 8'h00, 6'd0, 20'h0, 16'd1, 7'h0, 1'b1, 4'hD);
        load(6'd42, 8'h99, 6'd1, 20'h04200, 16'd10, 7'h07, 1'b0, 4'h0);
        lookup(4'hD, 8'h99, 16'd2, 3'b100);
        check("R11", "pre-flush hit latency", r_lat, 12);
        @(negedge clk);
        req_vaddr = {4'hD, 8'h99, 16'd2}; req_rwx = 3'b100; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        flush = 1'b1;
        #0.5;
        check("R11", "ready low during flush", 32'(req_ready), 0);
        @(negedge clk);
        flush = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (rsp_valid) seen = 1'b1;
            @(negedge clk);
        end
        check("R11", "aborted search silent", 32'(seen), 0);
        lookup(4'hD, 8'h99, 16'd2, 3'b100);
        check("R11", "slot cleared miss", 32'(r_miss), 1);
        check("R11", "slot cleared latency", r_lat, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_empty_slot();
        t_two_level();
        t_latency();
        t_bounds();
        t_rights();
        t_wrap();
        t_refs();
        t_priority();
        t_flush();
        summary();
        $finish;
    end
endmodule